// File: doc/BRIEF.md
# Variable Refresh Video Timing Generator

This block produces the raster timing for a display pipeline on the pixel clock: horizontal and vertical sync, a data-enable strobe and the column and row of the current active pixel. Every line is built as active pixels, then front porch, then sync pulse, then back porch; frames are built the same way from lines. Both sync outputs have a programmable polarity.

With variable refresh enabled, the frame no longer has a fixed number of lines. After the nominal back porch, the generator keeps adding blank lines until the source pulses a frame-ready strobe, and then starts the next frame at the following line boundary. The total line count of a frame is held between a programmed floor and ceiling. If no ready strobe has been seen when the ceiling is reached, the next frame begins anyway and is flagged as a repeat of the previous image. All timing inputs are captured only at a frame boundary, so the panel never sees a frame built from two configurations.

Top module: `vrr_timing_gen`

## Requirements
- R1: While reset is held, de_o, frame_start_o and frame_repeat_o are low and x_o and y_o are zero.
- R2: The horizontal period is h_active+h_front+h_sync+h_back cycles; hsync is in its asserted level for h_sync cycles, starting h_active+h_front cycles after the first pixel of the line.
- R3: vsync is in its asserted level for exactly the v_sync lines that start v_active+v_front lines after the frame's first line, and inactive on every other line, including stretched blank lines.
- R4: A polarity input of 1 makes the corresponding sync high when asserted and low otherwise; 0 inverts both levels.
- R5: de_o is high exactly when the column is below h_active and the row below v_active; while de_o is high x_o and y_o give the column and row counted from 0 at the frame's first pixel, and both are zero while de_o is low.
- R6: With variable refresh disabled each frame has exactly v_active+v_front+v_sync+v_back lines, frame_ready_i has no effect and frame_repeat_o stays low.
- R7: With variable refresh enabled, a ready strobe seen in line L (counted from 0) with L+1 at or above the floor ends the frame after line L, so the frame has L+1 lines.
- R8: A ready strobe seen before the floor is held, and the frame then has exactly floor lines.
- R9: When no ready strobe has been seen by the end of the ceiling line, the frame has ceiling lines and the next frame_start_o pulse comes with frame_repeat_o high; a frame that follows a ready strobe has frame_repeat_o low.
- R10: The floor is the larger of v_min_lines_i and the nominal vertical total, and the ceiling is the larger of v_max_lines_i and the floor.
- R11: All timing, polarity and mode inputs are sampled only when a frame begins; changing them mid-frame leaves the current frame unchanged and takes effect on the next one.
- R12: frame_start_o is a one-cycle pulse in the cycle of pixel (0,0) of each frame, and frame_repeat_o is only ever high together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_active_i | input | 12 | Active pixels per line |
| h_front_i | input | 12 | Horizontal front porch, cycles |
| h_sync_i | input | 12 | Horizontal sync width, cycles |
| h_back_i | input | 12 | Horizontal back porch, cycles |
| v_active_i | input | 12 | Active lines per frame |
| v_front_i | input | 12 | Vertical front porch, lines |
| v_sync_i | input | 12 | Vertical sync width, lines |
| v_back_i | input | 12 | Nominal vertical back porch, lines |
| hs_pol_i | input | 1 | hsync polarity, 1 = asserted high |
| vs_pol_i | input | 1 | vsync polarity, 1 = asserted high |
| vrr_en_i | input | 1 | Variable refresh mode enable |
| v_min_lines_i | input | 12 | Shortest frame in lines (variable mode) |
| v_max_lines_i | input | 12 | Longest frame in lines (variable mode) |
| frame_ready_i | input | 1 | One-cycle strobe: source has a new frame |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | 12 | Active pixel column |
| y_o | output | 12 | Active pixel row |
| frame_start_o | output | 1 | First pixel of a frame |
| frame_repeat_o | output | 1 | The starting frame repeats the previous image |

## Verification
A corrupted horizontal count shows within one line as a shifted hsync or de edge, while a wrong vertical count or a lost pending ready shows at the next frame boundary as a frame of the wrong length or a wrong repeat flag. The bench therefore predicts every output cycle by cycle from the programmed geometry and compares the cycle distance between frame starts with the line count implied by each frame's ready timing, including early, late, missing and ignored strobes and a window set below the nominal total.

// File: rtl/vrr_tg_pkg.sv
package vrr_tg_pkg;

  parameter int unsigned TG_HW = 12;
  parameter int unsigned TG_VW = 12;

  // raw programmed values as they arrive at the ports
  typedef struct packed {
    logic [TG_HW-1:0] h_act;
    logic [TG_HW-1:0] h_fp;
    logic [TG_HW-1:0] h_sw;
    logic [TG_HW-1:0] h_bp;
    logic [TG_VW-1:0] v_act;
    logic [TG_VW-1:0] v_fp;
    logic [TG_VW-1:0] v_sw;
    logic [TG_VW-1:0] v_bp;
    logic [TG_VW-1:0] v_min;
    logic [TG_VW-1:0] v_max;
    logic             hs_pol;
    logic             vs_pol;
    logic             vrr;
  } tg_req_t;

  // per-frame working copy with the derived boundaries
  typedef struct packed {
    logic [TG_HW-1:0] h_act;
    logic [TG_HW-1:0] hs_beg;
    logic [TG_HW-1:0] hs_end;
    logic [TG_HW-1:0] h_tot;
    logic [TG_VW-1:0] v_act;
    logic [TG_VW-1:0] vs_beg;
    logic [TG_VW-1:0] vs_end;
    logic [TG_VW-1:0] v_floor;
    logic [TG_VW-1:0] v_ceil;
    logic             hs_pol;
    logic             vs_pol;
    logic             vrr;
  } tg_cfg_t;

endpackage

// File: rtl/vrr_tg_cfg.sv
module vrr_tg_cfg
  import vrr_tg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load_en,
  input  tg_req_t req,
  output tg_cfg_t cfg_q
);

  tg_cfg_t          cfg_nxt;
  logic [TG_VW-1:0] v_nom;
  logic [TG_VW-1:0] floor_c;

  always_comb begin
    cfg_nxt        = '0;
    cfg_nxt.h_act  = req.h_act;
    cfg_nxt.hs_beg = req.h_act + req.h_fp;
    cfg_nxt.hs_end = req.h_act + req.h_fp + req.h_sw;
    cfg_nxt.h_tot  = req.h_act + req.h_fp + req.h_sw + req.h_bp;
    cfg_nxt.v_act  = req.v_act;
    cfg_nxt.vs_beg = req.v_act + req.v_fp;
    cfg_nxt.vs_end = req.v_act + req.v_fp + req.v_sw;
    v_nom          = req.v_act + req.v_fp + req.v_sw + req.v_bp;
    // window is never allowed to cut into the nominal frame
    if (req.vrr) begin
      floor_c         = (req.v_min > v_nom) ? req.v_min : v_nom;
      cfg_nxt.v_floor = floor_c;
      cfg_nxt.v_ceil  = (req.v_max > floor_c) ? req.v_max : floor_c;
    end else begin
      floor_c         = v_nom;
      cfg_nxt.v_floor = v_nom;
      cfg_nxt.v_ceil  = v_nom;
    end
    cfg_nxt.hs_pol = req.hs_pol;
    cfg_nxt.vs_pol = req.vs_pol;
    cfg_nxt.vrr    = req.vrr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load_en) begin
      cfg_q <= cfg_nxt;
    end
  end

  AST_WINDOW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cfg_q.v_floor <= cfg_q.v_ceil)); // R10

endmodule

// File: rtl/vrr_tg_hcnt.sv
module vrr_tg_hcnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] h_tot,
  output logic [W-1:0] hcnt,
  output logic         line_end
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] hcnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_en   = run;
    line_end = run && (hcnt == (h_tot - ONE));
    if (line_end) hcnt_nxt = '0;
    else          hcnt_nxt = hcnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
    end else if (cnt_en) begin
      hcnt <= hcnt_nxt;
    end
  end

  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hcnt < h_tot)); // R2

  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (hcnt == '0)); // R2

endmodule

// File: rtl/vrr_tg_vctl.sv
module vrr_tg_vctl #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         start,
  input  logic         line_end,
  input  logic         vrr,
  input  logic [W-1:0] v_floor,
  input  logic [W-1:0] v_ceil,
  input  logic         frame_ready,
  output logic [W-1:0] vcnt,
  output logic         frame_end,
  output logic         first_q,
  output logic         repeat_q
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] vcnt_nxt;
  logic [W-1:0] lines_done;
  logic         pend_q;
  logic         pend_nxt;
  logic         pend_eff;
  logic         rep_c;
  logic         first_nxt;
  logic         rep_nxt;
  logic         vcnt_en;

  always_comb begin
    lines_done = vcnt + ONE;
    pend_eff   = vrr && (pend_q || frame_ready);
    // close the frame once the floor is met with a ready pending, or at the ceiling
    frame_end  = line_end &&
                 (((lines_done >= v_floor) && pend_eff) || (lines_done >= v_ceil));
    rep_c      = vrr && !pend_eff;

    vcnt_en = run && line_end;
    if (frame_end) vcnt_nxt = '0;
    else           vcnt_nxt = lines_done;

    if (!run || frame_end)      pend_nxt = 1'b0;
    else if (vrr && frame_ready) pend_nxt = 1'b1;
    else                         pend_nxt = pend_q;

    first_nxt = start || frame_end;
    rep_nxt   = frame_end && rep_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
    end else if (vcnt_en) begin
      vcnt <= vcnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      first_q  <= 1'b0;
      repeat_q <= 1'b0;
    end else begin
      pend_q   <= pend_nxt;
      first_q  <= first_nxt;
      repeat_q <= rep_nxt;
    end
  end

  AST_VCNT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (vcnt < v_ceil)); // R9

  AST_FIXED_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !vrr) |=> !repeat_q); // R6

  AST_REPEAT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_q |-> first_q); // R12

  AST_HOLD_BELOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && (vcnt + ONE < v_floor)) |=> (vcnt != '0)); // R8

endmodule

// File: rtl/vrr_timing_gen.sv
module vrr_timing_gen
  import vrr_tg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TG_HW-1:0] h_active_i,
  input  logic [TG_HW-1:0] h_front_i,
  input  logic [TG_HW-1:0] h_sync_i,
  input  logic [TG_HW-1:0] h_back_i,
  input  logic [TG_VW-1:0] v_active_i,
  input  logic [TG_VW-1:0] v_front_i,
  input  logic [TG_VW-1:0] v_sync_i,
  input  logic [TG_VW-1:0] v_back_i,
  input  logic             hs_pol_i,
  input  logic             vs_pol_i,
  input  logic             vrr_en_i,
  input  logic [TG_VW-1:0] v_min_lines_i,
  input  logic [TG_VW-1:0] v_max_lines_i,
  input  logic             frame_ready_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [TG_HW-1:0] x_o,
  output logic [TG_VW-1:0] y_o,
  output logic             frame_start_o,
  output logic             frame_repeat_o
);

  tg_req_t          req;
  tg_cfg_t          cfg_q;
  logic             run_q;
  logic             start;
  logic             load_en;
  logic [TG_HW-1:0] hcnt;
  logic [TG_VW-1:0] vcnt;
  logic             line_end;
  logic             frame_end;
  logic             first_q;
  logic             repeat_q;

  logic             h_in, v_in, hs_on, vs_on, de_c;
  logic             hs_nxt, vs_nxt;
  logic [TG_HW-1:0] x_nxt;
  logic [TG_VW-1:0] y_nxt;

  always_comb begin
    req.h_act  = h_active_i;
    req.h_fp   = h_front_i;
    req.h_sw   = h_sync_i;
    req.h_bp   = h_back_i;
    req.v_act  = v_active_i;
    req.v_fp   = v_front_i;
    req.v_sw   = v_sync_i;
    req.v_bp   = v_back_i;
    req.v_min  = v_min_lines_i;
    req.v_max  = v_max_lines_i;
    req.hs_pol = hs_pol_i;
    req.vs_pol = vs_pol_i;
    req.vrr    = vrr_en_i;
  end

  // first cycle after reset captures the configuration, then the raster runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign start   = !run_q;
  assign load_en = start || frame_end;

  vrr_tg_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .req     (req),
    .cfg_q   (cfg_q)
  );

  vrr_tg_hcnt #(.W(TG_HW)) u_hcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .h_tot    (cfg_q.h_tot),
    .hcnt     (hcnt),
    .line_end (line_end)
  );

  vrr_tg_vctl #(.W(TG_VW)) u_vctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_q),
    .start       (start),
    .line_end    (line_end),
    .vrr         (cfg_q.vrr),
    .v_floor     (cfg_q.v_floor),
    .v_ceil      (cfg_q.v_ceil),
    .frame_ready (frame_ready_i),
    .vcnt        (vcnt),
    .frame_end   (frame_end),
    .first_q     (first_q),
    .repeat_q    (repeat_q)
  );

  always_comb begin
    h_in   = hcnt < cfg_q.h_act;
    v_in   = vcnt < cfg_q.v_act;
    hs_on  = (hcnt >= cfg_q.hs_beg) && (hcnt < cfg_q.hs_end);
    vs_on  = (vcnt >= cfg_q.vs_beg) && (vcnt < cfg_q.vs_end);
    de_c   = run_q && h_in && v_in;
    hs_nxt = hs_on ~^ cfg_q.hs_pol;
    vs_nxt = vs_on ~^ cfg_q.vs_pol;
    x_nxt  = de_c ? hcnt : '0;
    y_nxt  = de_c ? vcnt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o        <= 1'b0;
      vsync_o        <= 1'b0;
      de_o           <= 1'b0;
      x_o            <= '0;
      y_o            <= '0;
      frame_start_o  <= 1'b0;
      frame_repeat_o <= 1'b0;
    end else begin
      hsync_o        <= hs_nxt;
      vsync_o        <= vs_nxt;
      de_o           <= de_c;
      x_o            <= x_nxt;
      y_o            <= y_nxt;
      frame_start_o  <= first_q;
      frame_repeat_o <= repeat_q;
    end
  end

  AST_REPEAT_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_repeat_o |-> frame_start_o); // R12

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o); // R12

  AST_DE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> ((x_o < cfg_q.h_act) && (y_o < cfg_q.v_act))); // R5

  AST_COORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> ((x_o == '0) && (y_o == '0))); // R5

endmodule

// File: tb/vrr_timing_gen_tb_top.sv
module vrr_timing_gen_tb_top;
  import vrr_tg_pkg::*;

  typedef struct {
    int ha, hfp, hs, hbp;
    int va, vfp, vs, vbp;
    int vmin, vmax;
    bit hp, vp, vrr;
  } tcfg_t;

  typedef struct {
    tcfg_t c;
    int    lines;
    bit    rep;
    string tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [TG_HW-1:0] h_active_i, h_front_i, h_sync_i, h_back_i;
  logic [TG_VW-1:0] v_active_i, v_front_i, v_sync_i, v_back_i;
  logic             hs_pol_i, vs_pol_i, vrr_en_i;
  logic [TG_VW-1:0] v_min_lines_i, v_max_lines_i;
  logic             frame_ready_i;
  logic             hsync_o, vsync_o, de_o, frame_start_o, frame_repeat_o;
  logic [TG_HW-1:0] x_o;
  logic [TG_VW-1:0] y_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    prev_rep = 1'b0;
  item_t sbq[$];

  always #10 clk = ~clk;

  vrr_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_active_i(h_active_i), .h_front_i(h_front_i), .h_sync_i(h_sync_i), .h_back_i(h_back_i),
    .v_active_i(v_active_i), .v_front_i(v_front_i), .v_sync_i(v_sync_i), .v_back_i(v_back_i),
    .hs_pol_i(hs_pol_i), .vs_pol_i(vs_pol_i), .vrr_en_i(vrr_en_i),
    .v_min_lines_i(v_min_lines_i), .v_max_lines_i(v_max_lines_i),
    .frame_ready_i(frame_ready_i),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .x_o(x_o), .y_o(y_o),
    .frame_start_o(frame_start_o), .frame_repeat_o(frame_repeat_o)
  );

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int htot(input tcfg_t c);
    return c.ha + c.hfp + c.hs + c.hbp;
  endfunction

  function automatic int vnom(input tcfg_t c);
    return c.va + c.vfp + c.vs + c.vbp;
  endfunction

  // line count from the window rules (R7 R8 R9 R10 R6)
  function automatic int exp_lines(input tcfg_t c, input int rl);
    int fl, cl;
    if (!c.vrr) return vnom(c);
    fl = (c.vmin > vnom(c)) ? c.vmin : vnom(c);
    cl = (c.vmax > fl) ? c.vmax : fl;
    if (rl < 0) return cl;
    if (rl + 1 > fl) return rl + 1;
    return fl;
  endfunction

  task automatic apply(input tcfg_t c);
    h_active_i    = TG_HW'(c.ha);
    h_front_i     = TG_HW'(c.hfp);
    h_sync_i      = TG_HW'(c.hs);
    h_back_i      = TG_HW'(c.hbp);
    v_active_i    = TG_VW'(c.va);
    v_front_i     = TG_VW'(c.vfp);
    v_sync_i      = TG_VW'(c.vs);
    v_back_i      = TG_VW'(c.vbp);
    v_min_lines_i = TG_VW'(c.vmin);
    v_max_lines_i = TG_VW'(c.vmax);
    hs_pol_i      = c.hp;
    vs_pol_i      = c.vp;
    vrr_en_i      = c.vrr;
  endtask

  task automatic wait_fs();
    @(negedge clk);
    while (!frame_start_o) @(negedge clk);
  endtask

  // driver: queue the expectation, program the inputs, run the frame
  task automatic do_frame(input tcfg_t c, input int rl, input string tag);
    item_t it;
    it.c     = c;
    it.lines = exp_lines(c, rl);
    it.rep   = prev_rep;
    it.tag   = tag;
    sbq.push_back(it);
    apply(c);
    wait_fs();
    if (rl >= 0) begin
      repeat (rl * htot(c) + htot(c) / 2) @(negedge clk);
      frame_ready_i = 1'b1;
      @(negedge clk);
      frame_ready_i = 1'b0;
    end
    prev_rep = c.vrr && (rl < 0);
  endtask

  // monitor: per-cycle geometry, frame length and repeat flag
  item_t cur;
  bit    have = 1'b0;
  int    pos = 0;
  int    mm = 0;
  string mmsg;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (frame_start_o) begin
        if (have) begin
          chk(mm == 0, $sformatf("R2 R3 R4 R5 R11 geometry (%s): %s", cur.tag, mmsg));
          chk(pos == htot(cur.c) * cur.lines,
              $sformatf("%s frame length act=%0d exp=%0d", cur.tag, pos, htot(cur.c) * cur.lines));
        end
        if (sbq.size() > 0) begin
          cur  = sbq.pop_front();
          have = 1'b1;
          chk(frame_repeat_o == cur.rep,
              $sformatf("R9 R12 repeat flag (%s) act=%0b exp=%0b", cur.tag, frame_repeat_o, cur.rep));
        end else begin
          have = 1'b0;
        end
        pos = 0;
        mm  = 0;
        mmsg = "";
      end
      if (have) begin
        int  ht, col, row;
        bit  e_de, e_hs, e_vs;
        int  e_x, e_y;
        ht   = htot(cur.c);
        col  = pos % ht;
        row  = pos / ht;
        e_de = (col < cur.c.ha) && (row < cur.c.va);
        e_hs = ((col >= cur.c.ha + cur.c.hfp) && (col < cur.c.ha + cur.c.hfp + cur.c.hs)) ? cur.c.hp : !cur.c.hp;
        e_vs = ((row >= cur.c.va + cur.c.vfp) && (row < cur.c.va + cur.c.vfp + cur.c.vs)) ? cur.c.vp : !cur.c.vp;
        e_x  = e_de ? col : 0;
        e_y  = e_de ? row : 0;
        if (de_o !== e_de || hsync_o !== e_hs || vsync_o !== e_vs ||
            int'(x_o) != e_x || int'(y_o) != e_y ||
            frame_start_o !== (pos == 0) || (pos != 0 && frame_repeat_o !== 1'b0)) begin
          if (mm == 0)
            mmsg = $sformatf("pos=%0d act de=%0b hs=%0b vs=%0b x=%0d y=%0d fs=%0b exp de=%0b hs=%0b vs=%0b x=%0d y=%0d",
                             pos, de_o, hsync_o, vsync_o, x_o, y_o, frame_start_o, e_de, e_hs, e_vs, e_x, e_y);
          mm++;
        end
        pos++;
      end
    end
  end

  initial begin
    tcfg_t a, b, c, d;
    a = '{ha:8, hfp:2, hs:3, hbp:3, va:4, vfp:1, vs:2, vbp:1, vmin:0, vmax:0, hp:1'b1, vp:1'b1, vrr:1'b0};
    b = '{ha:10, hfp:2, hs:4, hbp:2, va:4, vfp:1, vs:2, vbp:1, vmin:0, vmax:0, hp:1'b0, vp:1'b0, vrr:1'b0};
    c = '{ha:8, hfp:2, hs:3, hbp:3, va:4, vfp:1, vs:2, vbp:1, vmin:10, vmax:14, hp:1'b1, vp:1'b0, vrr:1'b1};
    d = '{ha:8, hfp:2, hs:3, hbp:3, va:4, vfp:1, vs:2, vbp:1, vmin:3, vmax:5, hp:1'b0, vp:1'b1, vrr:1'b1};
    rst_n = 1'b0;
    frame_ready_i = 1'b0;
    apply(a);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(de_o == 1'b0 && frame_start_o == 1'b0 && frame_repeat_o == 1'b0 && x_o == '0 && y_o == '0,
        $sformatf("R1 reset outputs act de=%0b fs=%0b rep=%0b x=%0d y=%0d exp all zero",
                  de_o, frame_start_o, frame_repeat_o, x_o, y_o));
    rst_n = 1'b1;
    do_frame(a, 2,  "R6 fixed, ready ignored");
    do_frame(b, -1, "R4 R11 new geometry and inverted polarity");
    do_frame(c, 11, "R7 late ready");
    do_frame(c, 1,  "R8 early ready held");
    do_frame(c, -1, "R9 no ready, ceiling");
    do_frame(c, 9,  "R9 repeat then ready at floor");
    do_frame(d, -1, "R10 window below nominal");
    do_frame(d, 0,  "R10 repeat of nominal frame");
    do_frame(a, 1,  "R6 back to fixed");
    do_frame(a, -1, "R6 last start");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog act=timeout exp=frame starts");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule